// File: doc/BRIEF.md
# Multi-Queue Descriptor Response Ring Manager

This block holds five circular response queues that sit between a packet-filter engine (the producer) and a host processor (the consumer). For each packet it has handled, the filter engine presents one 32-bit descriptor address with four match flags: buy, sell, market data and management. In a single cycle the manager writes that descriptor into every queue whose flag is set. It also writes the descriptor into a fifth recycle queue, which logs every handled descriptor whatever its flags say. Each queue that accepts the write advances its write pointer and raises its own sticky doorbell bit toward the host.

The host drains the queues one entry at a time through a pop port that names a queue. It clears doorbells by writing ones to them. It can read back the write and read pointer of any queue through a selector port. Empty, full and sticky overflow flags for all five queues are visible at all times. Every queue has the same depth, which is a power of two. One slot is kept unused so that a full queue can be told apart from an empty one, so each queue holds at most depth minus one entries.

Top module: `resp_ring_mgr`

## Requirements
- R1: After reset every queue is empty, not full and not overflowed, all pointers read 0, all doorbells are 0 and pop_valid is 0.
- R2: Every push writes its descriptor into the recycle queue (queue index 4) whatever the match flags are, unless that queue is full.
- R3: On a push, each queue whose match bit is set (bit 0 buy = queue 0, bit 1 sell = queue 1, bit 2 market data = queue 2, bit 3 management = queue 3) receives the descriptor in the same cycle. Its write pointer advances by one.
- R4: A queue is empty when its two pointers are equal and full when the write pointer plus one equals the read pointer modulo the depth. It holds at most DEPTH-1 entries.
- R5: A push aimed at a full queue is dropped for that queue only and sets that queue's overflow bit, which stays set until reset. The other target queues of the same push still accept it.
- R6: A doorbell bit is set on the edge where its queue accepts a descriptor and stays set until a 1 is written to its db_clr bit. If a clear and an accepted write arrive in the same cycle, the bit stays set.
- R7: A pop of a non-empty queue returns that queue's oldest entry on pop_data with pop_valid high one cycle later and advances its read pointer. A pop of an empty queue, or with a pop_sel value of 5 or more, gives pop_valid low and changes no state.
- R8: Pointers wrap at DEPTH, and entries leave each queue in the order they entered, across any number of wraps.
- R9: On the edge after ptr_sel names a queue, ptr_wr and ptr_rd show that queue's write and read pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Filter engine presents a handled descriptor |
| push_desc | input | DESC_W | Descriptor address |
| push_match | input | 4 | Match flags: buy, sell, market data, management |
| pop_req | input | 1 | Host takes one entry |
| pop_sel | input | 3 | Queue index to pop |
| pop_valid | output | 1 | pop_data holds a popped entry |
| pop_data | output | DESC_W | Popped descriptor |
| db_clr | input | 5 | Write-one-to-clear doorbell bits |
| doorbell | output | 5 | Sticky per-queue doorbells |
| ptr_sel | input | 3 | Queue whose pointers are read back |
| ptr_wr | output | log2(DEPTH) | Write pointer of the selected queue |
| ptr_rd | output | log2(DEPTH) | Read pointer of the selected queue |
| q_empty | output | 5 | Per-queue empty flags |
| q_full | output | 5 | Per-queue full flags |
| q_ovf | output | 5 | Per-queue sticky overflow flags |

## Verification
Every result of this block is due on the first rising edge after its stimulus is sampled. The empty, full and overflow flags and the doorbells reflect a push or clear from that edge on. Popped data and pop_valid appear one cycle after pop_req. Pointer readback follows ptr_sel by one cycle. The bench drives every input on the falling edge and samples one falling edge later, so each check lands in the cycle its register updates. Popped data is matched against a per-queue reference model by a monitor that runs on the same falling edge.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int NMATCH    = 4;
  localparam int NQ        = NMATCH + 1;
  localparam int QSEL_W    = 3;
  localparam int RECYCLE_Q = NMATCH;

  typedef enum logic [QSEL_W-1:0] {
    Q_BUY     = 3'd0,
    Q_SELL    = 3'd1,
    Q_MDATA   = 3'd2,
    Q_MGMT    = 3'd3,
    Q_RECYCLE = 3'd4
  } queue_id_e;
endpackage

// File: rtl/rrm_route.sv
module rrm_route
  import rrm_pkg::*;
(
  input  logic              push_valid,
  input  logic [NMATCH-1:0] push_match,
  input  logic              pop_req,
  input  logic [QSEL_W-1:0] pop_sel,
  output logic [NQ-1:0]     wr_tgt,
  output logic [NQ-1:0]     rd_tgt
);
  for (genvar q = 0; q < NQ; q++) begin : g_route
    if (q == RECYCLE_Q) begin : g_recycle
      // the log queue takes every handled descriptor
      assign wr_tgt[q] = push_valid;
    end else begin : g_match
      assign wr_tgt[q] = push_valid & push_match[q];
    end
    assign rd_tgt[q] = pop_req & (pop_sel == QSEL_W'(q));
  end
endmodule

// File: rtl/rrm_ring.sv
module rrm_ring #(
  parameter int DESC_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DESC_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              bell_clr,
  output logic              rd_valid,
  output logic [DESC_W-1:0] rd_data,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              bell
);
  logic [DESC_W-1:0] mem [DEPTH];
  logic wr_ok, rd_ok;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = ((wr_ptr + AW'(1)) == rd_ptr);
  assign wr_ok = wr_req & ~full;
  assign rd_ok = rd_req & ~empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      ovf      <= 1'b0;
      bell     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
      if (wr_req && full) ovf <= 1'b1;
      // an accepted write outranks a clear in the same cycle
      if (wr_ok)         bell <= 1'b1;
      else if (bell_clr) bell <= 1'b0;
    end
  end

  a_r4_full_empty_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_req) |=> ($stable(wr_ptr) && ovf));
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r6_bell_on_write: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !full) |=> bell);
  a_r7_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> (!rd_valid && $stable(rd_ptr)));
endmodule

// File: rtl/rrm_readback.sv
module rrm_readback
  import rrm_pkg::*;
#(
  parameter int DESC_W = 32,
  parameter int AW     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [QSEL_W-1:0]         ptr_sel,
  input  logic [NQ-1:0][AW-1:0]     wp_all,
  input  logic [NQ-1:0][AW-1:0]     rp_all,
  input  logic [NQ-1:0]             vld_all,
  input  logic [NQ-1:0][DESC_W-1:0] dat_all,
  output logic                      pop_valid,
  output logic [DESC_W-1:0]         pop_data,
  output logic [AW-1:0]             ptr_wr,
  output logic [AW-1:0]             ptr_rd
);
  logic [AW-1:0] wp_sel, rp_sel;

  always_comb begin
    wp_sel = '0;
    rp_sel = '0;
    for (int q = 0; q < NQ; q++) begin
      if (ptr_sel == QSEL_W'(q)) begin
        wp_sel = wp_all[q];
        rp_sel = rp_all[q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_wr <= '0;
      ptr_rd <= '0;
    end else begin
      ptr_wr <= wp_sel;
      ptr_rd <= rp_sel;
    end
  end

  // at most one ring returns data per cycle, so an OR merge suffices
  always_comb begin
    pop_data = '0;
    for (int q = 0; q < NQ; q++) begin
      if (vld_all[q]) pop_data = pop_data | dat_all[q];
    end
  end
  assign pop_valid = |vld_all;

  a_r7_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vld_all));
endmodule

// File: rtl/resp_ring_mgr.sv
module resp_ring_mgr
  import rrm_pkg::*;
#(
  parameter int DESC_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push_valid,
  input  logic [DESC_W-1:0]        push_desc,
  input  logic [NMATCH-1:0]        push_match,
  input  logic                     pop_req,
  input  logic [QSEL_W-1:0]        pop_sel,
  output logic                     pop_valid,
  output logic [DESC_W-1:0]        pop_data,
  input  logic [NQ-1:0]            db_clr,
  output logic [NQ-1:0]            doorbell,
  input  logic [QSEL_W-1:0]        ptr_sel,
  output logic [$clog2(DEPTH)-1:0] ptr_wr,
  output logic [$clog2(DEPTH)-1:0] ptr_rd,
  output logic [NQ-1:0]            q_empty,
  output logic [NQ-1:0]            q_full,
  output logic [NQ-1:0]            q_ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [NQ-1:0]             wr_tgt, rd_tgt, vld_all;
  logic [NQ-1:0][AW-1:0]     wp_all, rp_all;
  logic [NQ-1:0][DESC_W-1:0] dat_all;

  rrm_route u_route (
    .push_valid (push_valid),
    .push_match (push_match),
    .pop_req    (pop_req),
    .pop_sel    (pop_sel),
    .wr_tgt     (wr_tgt),
    .rd_tgt     (rd_tgt)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_ring
    rrm_ring #(.DESC_W(DESC_W), .DEPTH(DEPTH)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .wr_req   (wr_tgt[q]),
      .wr_data  (push_desc),
      .rd_req   (rd_tgt[q]),
      .bell_clr (db_clr[q]),
      .rd_valid (vld_all[q]),
      .rd_data  (dat_all[q]),
      .wr_ptr   (wp_all[q]),
      .rd_ptr   (rp_all[q]),
      .empty    (q_empty[q]),
      .full     (q_full[q]),
      .ovf      (q_ovf[q]),
      .bell     (doorbell[q])
    );
  end

  rrm_readback #(.DESC_W(DESC_W), .AW(AW)) u_readback (
    .clk       (clk),
    .rst       (rst),
    .ptr_sel   (ptr_sel),
    .wp_all    (wp_all),
    .rp_all    (rp_all),
    .vld_all   (vld_all),
    .dat_all   (dat_all),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .ptr_wr    (ptr_wr),
    .ptr_rd    (ptr_rd)
  );

  a_r2_recycle_always: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !q_full[RECYCLE_Q]) |=> doorbell[RECYCLE_Q]);
  a_r3_match_rings_bell: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_match[0] && !q_full[0]) |=> doorbell[0]);
endmodule

// File: tb/test_resp_ring_mgr.sv
module test_resp_ring_mgr;
  import rrm_pkg::*;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              push_valid = 1'b0;
  logic [DW-1:0]     push_desc  = '0;
  logic [NMATCH-1:0] push_match = '0;
  logic              pop_req    = 1'b0;
  logic [QSEL_W-1:0] pop_sel    = '0;
  logic [NQ-1:0]     db_clr     = '0;
  logic [QSEL_W-1:0] ptr_sel    = '0;
  logic              pop_valid;
  logic [DW-1:0]     pop_data;
  logic [NQ-1:0]     doorbell, q_empty, q_full, q_ovf;
  logic [AW-1:0]     ptr_wr, ptr_rd;

  resp_ring_mgr #(.DESC_W(DW), .DEPTH(DEPTH)) i_resp_ring_mgr (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_desc(push_desc),
    .push_match(push_match), .pop_req(pop_req), .pop_sel(pop_sel),
    .pop_valid(pop_valid), .pop_data(pop_data), .db_clr(db_clr),
    .doorbell(doorbell), .ptr_sel(ptr_sel), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd),
    .q_empty(q_empty), .q_full(q_full), .q_ovf(q_ovf)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] mq [NQ][$];
  int            mwp [NQ];
  int            mrp [NQ];
  logic [NQ-1:0] movf = '0;
  logic [NQ-1:0] mdb  = '0;
  logic [DW-1:0] sb [$];
  logic [DW-1:0] exp_d;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic do_push(logic [DW-1:0] d, logic [NMATCH-1:0] m, logic [NQ-1:0] clr);
    logic [NQ-1:0] acc;
    bit tgt;
    acc = '0;
    @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      tgt = (q < NMATCH) ? m[q] : 1'b1;
      if (tgt) begin
        if (mq[q].size() == DEPTH - 1) movf[q] = 1'b1;
        else begin
          mq[q].push_back(d);
          mwp[q]++;
          acc[q] = 1'b1;
        end
      end
    end
    mdb = (mdb & ~clr) | acc;
    push_valid = 1'b1; push_desc = d; push_match = m; db_clr = clr;
    @(negedge clk);
    push_valid = 1'b0; db_clr = '0;
  endtask

  task automatic do_clr(logic [NQ-1:0] clr);
    @(negedge clk);
    mdb = mdb & ~clr;
    db_clr = clr;
    @(negedge clk);
    db_clr = '0;
  endtask

  task automatic do_pop(int q);
    bit emp;
    @(negedge clk);
    if (q < NQ && mq[q].size() > 0) begin
      sb.push_back(mq[q].pop_front());
      mrp[q]++;
      emp = 1'b0;
    end else emp = 1'b1;
    pop_req = 1'b1; pop_sel = QSEL_W'(q);
    @(negedge clk);
    pop_req = 1'b0;
    if (emp) chk("R7 empty or invalid pop gives no data", 64'(pop_valid), 64'(0));
  endtask

  task automatic check_status(string tag);
    logic [NQ-1:0] e, f;
    for (int q = 0; q < NQ; q++) begin
      e[q] = (mq[q].size() == 0);
      f[q] = (mq[q].size() == DEPTH - 1);
    end
    chk({tag, " R4 empty flags"}, 64'(q_empty), 64'(e));
    chk({tag, " R4 full flags"}, 64'(q_full), 64'(f));
    chk({tag, " R5 overflow flags"}, 64'(q_ovf), 64'(movf));
    chk({tag, " R6 doorbells"}, 64'(doorbell), 64'(mdb));
  endtask

  task automatic check_ptrs(string tag, int q);
    @(negedge clk);
    ptr_sel = QSEL_W'(q);
    @(negedge clk);
    chk({tag, " R9 write pointer"}, 64'(ptr_wr), 64'(mwp[q] % DEPTH));
    chk({tag, " R9 read pointer"}, 64'(ptr_rd), 64'(mrp[q] % DEPTH));
  endtask

  task automatic drain_all();
    for (int q = 0; q < NQ; q++)
      while (mq[q].size() > 0) do_pop(q);
  endtask

  // monitor: compares every popped entry with the scoreboard front
  always @(negedge clk) begin
    if (!rst && pop_valid) begin
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected pop: actual %0h expected none", pop_data);
      end else begin
        exp_d = sb.pop_front();
        chk("R7 R8 popped entry order", 64'(pop_data), 64'(exp_d));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      mwp[q] = 0;
      mrp[q] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 reset empty", 64'(q_empty), 64'(5'h1f));
    chk("R1 reset full", 64'(q_full), 64'(0));
    chk("R1 reset overflow", 64'(q_ovf), 64'(0));
    chk("R1 reset doorbell", 64'(doorbell), 64'(0));
    chk("R1 reset pop_valid", 64'(pop_valid), 64'(0));
    check_ptrs("R1", 4);

    // R3 fan-out: buy plus market data
    do_push(32'hA000_0010, 4'b0101, '0);
    chk("R3 doorbell after buy+mdata", 64'(doorbell), 64'(5'b10101));
    check_status("R3");
    // R2 recycle-only and other patterns
    do_push(32'hB000_0020, 4'b0110, '0);
    do_push(32'hC000_0030, 4'b1000, '0);
    do_push(32'hD000_0040, 4'b0000, '0);
    check_status("R2");
    check_ptrs("R2", 4);

    // R6 clear, then clear racing a push
    do_clr(5'b00001);
    check_status("R6 clear");
    do_push(32'hE000_0050, 4'b0000, 5'b10000);
    chk("R6 push wins over clear", 64'(doorbell[4]), 64'(1));

    // R7 drain, including empty and invalid pops
    drain_all();
    do_pop(0);
    do_pop(6);
    check_status("R7");

    // R4 fill buy and recycle, R5 partial acceptance
    for (int i = 0; i < DEPTH - 1; i++) do_push(32'h1000_0000 + i, 4'b0001, '0);
    check_status("R4 full");
    do_push(32'h2000_0000, 4'b0011, '0);
    chk("R5 overflow on buy and recycle", 64'(q_ovf), 64'(5'b10001));
    check_status("R5");
    check_ptrs("R5", 1);
    check_ptrs("R5", 0);
    drain_all();
    check_status("R4 drained");

    // R8 wrap on the market data queue
    for (int i = 0; i < 3 * DEPTH; i++) begin
      do_push(32'h3000_0000 + i, 4'b0100, '0);
      do_push(32'h3100_0000 + i, 4'b0100, '0);
      do_pop(2);
      do_pop(4);
      do_pop(4);
    end
    check_ptrs("R8", 2);
    check_ptrs("R8", 4);
    drain_all();
    check_status("R8");

    repeat (3) @(negedge clk);
    chk("R7 scoreboard empty at end", 64'(sb.size()), 64'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule